// File: doc/BRIEF.md
# Synchronous I/Q Beam Phase Detector

The detector accepts one sample per cycle from each of four pick-up electrode converters. All four converters are clocked synchronously with the beam. The intermediate frequency sits at thirteen quarters of the sampling rate, so the carrier advances by a quarter turn between consecutive samples. As a result, the sum of the four channels visits the in-phase, quadrature, negated in-phase and negated quadrature projections in turn. The block sums the four channels for each sample and restores the sign of the third and fourth sample of each group of four. It pairs an in-phase value with the quadrature value that follows it. No numerically controlled oscillator or digital mixer is needed. The phase reference is a signal at one quarter of the sampling clock.

Each I/Q pair goes into a fully pipelined vectoring CORDIC with 16 micro-rotations, a quadrant pre-rotation and a gain-correcting multiplier. The CORDIC produces the vector magnitude and a four-quadrant angle. A revolution strobe restarts the four-step sequence, so the pairing stays locked to the beam's time structure across turns and gaps in the sample stream.

The sequencer is a four-state machine. Its states are SEQ_I (awaiting an in-phase sample), SEQ_Q (awaiting a quadrature sample), SEQ_NI (awaiting a negated in-phase sample) and SEQ_NQ (awaiting a negated quadrature sample). Each accepted sample moves it one step around the ring SEQ_I → SEQ_Q → SEQ_NI → SEQ_NQ → SEQ_I. When the revolution strobe is high, the effective state for that cycle is SEQ_I, whatever the stored state is. A sample in SEQ_Q or SEQ_NQ completes a pair.

Top module: `beam_iq_phase_det`

## Requirements
- R1: While rst_n is low, out_valid, out_amp and out_phase are all zero. The first accepted sample after reset is treated as an in-phase sample.
- R2: Accepted samples are numbered 0,1,2,3 cyclically. The four-channel sum of sample 0 gives I and sample 1 gives Q. Sample 2 gives I negated and sample 3 gives Q negated. A sample at position 1 or 3 is paired with the sample just before it.
- R3: A cycle with in_valid low does not advance the sequence and produces no result. Exactly one result is produced for each completed pair.
- R4: A sample accepted with rev_sync high is taken as sequence position 0. A rev_sync pulse with in_valid low makes the next accepted sample position 0. A half-finished pair is dropped.
- R5: out_amp is sqrt(I²+Q²), unsigned, within 2 + amp/1024 LSB.
- R6: out_phase is a signed 16-bit value equal to atan2(Q,I)·32768/π. An angle of +π reads as -32768. For amplitudes of 512 and above it is within 16 LSB (modulo 2^16), in all four quadrants.
- R7: For I = Q = 0, out_amp and out_phase are both 0.
- R8: out_valid rises exactly 18 clock edges after the edge that accepts the second sample of a pair, and stays high for one cycle per result.
- R9: The block accepts a sample on every cycle without stalling and loses no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The four channel samples are valid this cycle |
| ch_a | input | SAMPLE_W | Electrode A sample, two's complement |
| ch_b | input | SAMPLE_W | Electrode B sample, two's complement |
| ch_c | input | SAMPLE_W | Electrode C sample, two's complement |
| ch_d | input | SAMPLE_W | Electrode D sample, two's complement |
| rev_sync | input | 1 | Revolution strobe, restarts the four-step sequence |
| out_valid | output | 1 | Result valid, one cycle per pair |
| out_amp | output | SAMPLE_W+3 | Vector magnitude, unsigned |
| out_phase | output | PH_W | Angle as a signed fraction of π |

## Verification
Directed sequences across all four sample positions use distinct values on each electrode. A missing or misplaced sign restore shows up as a phase error near π. A vector sweep through every quadrant and the ±π boundary shows whether the pre-rotation and the angle wrap are correct. Tiny and zero vectors expose the zero special case. Revolution strobes are placed with and without a sample, and on positions that would otherwise be quadrature or negated. Idle cycles carry random channel values, which shows whether invalid samples leak into the pairing. A back-to-back stream and a long random stream with gaps and occasional strobes test throughput and the latency against a bench model.

// File: rtl/iq_pkg.sv
package iq_pkg;

    // Position in the four-step undersampled carrier sequence
    typedef enum logic [1:0] {
        SEQ_I  = 2'd0,
        SEQ_Q  = 2'd1,
        SEQ_NI = 2'd2,
        SEQ_NQ = 2'd3
    } seq_state_e;

    // atan(2^-idx) scaled so that pi equals 2^17
    function automatic int atan_pi17(input int idx);
        int r;
        case (idx)
            0:  r = 32768;
            1:  r = 19344;
            2:  r = 10221;
            3:  r = 5188;
            4:  r = 2604;
            5:  r = 1303;
            6:  r = 652;
            7:  r = 326;
            8:  r = 163;
            9:  r = 81;
            10: r = 41;
            11: r = 20;
            12: r = 10;
            13: r = 5;
            14: r = 3;
            15: r = 1;
            default: r = 41722 >>> idx;
        endcase
        return r;
    endfunction

    // 1/K of a long CORDIC chain, scaled by 2^16
    localparam int CORDIC_INV_GAIN = 39797;
    localparam int INV_GAIN_FRAC   = 16;

endpackage

// File: rtl/iq_chan_sum.sv
module iq_chan_sum #(
    parameter int SAMPLE_W = 12,
    parameter int N_CH     = 4,
    parameter int IQ_W     = SAMPLE_W + $clog2(N_CH) + 1
) (
    input  logic [N_CH-1:0][SAMPLE_W-1:0] lanes,
    output logic signed [IQ_W-1:0]        sum
);

    always_comb begin
        sum = '0;
        for (int k = 0; k < N_CH; k++) begin
            sum = sum + IQ_W'($signed(lanes[k]));
        end
    end

endmodule

// File: rtl/iq_pair_former.sv
module iq_pair_former
    import iq_pkg::*;
#(
    parameter int IQ_W = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   rev_sync,
    input  logic signed [IQ_W-1:0] chan_sum,
    output logic                   pair_valid,
    output logic signed [IQ_W-1:0] pair_i,
    output logic signed [IQ_W-1:0] pair_q
);

    seq_state_e             state_q;
    seq_state_e             eff_state;
    seq_state_e             state_d;
    logic signed [IQ_W-1:0] signed_sum;
    logic signed [IQ_W-1:0] i_hold_q;

    // Effective position: the revolution strobe forces a fresh group
    always_comb begin
        eff_state = rev_sync ? SEQ_I : state_q;
        state_d   = eff_state;
        if (in_valid) begin
            unique case (eff_state)
                SEQ_I:  state_d = SEQ_Q;
                SEQ_Q:  state_d = SEQ_NI;
                SEQ_NI: state_d = SEQ_NQ;
                SEQ_NQ: state_d = SEQ_I;
            endcase
        end
        signed_sum = (eff_state == SEQ_NI || eff_state == SEQ_NQ) ? -chan_sum : chan_sum;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_I;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: hold the in-phase half, emit on the quadrature half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_hold_q   <= '0;
            pair_i     <= '0;
            pair_q     <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (in_valid) begin
                unique case (eff_state)
                    SEQ_I, SEQ_NI: begin
                        i_hold_q <= signed_sum;
                    end
                    SEQ_Q, SEQ_NQ: begin
                        pair_i     <= i_hold_q;
                        pair_q     <= signed_sum;
                        pair_valid <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R3
    pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R4
    realign_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_sync && in_valid) |=> (state_q == SEQ_Q));

    // R4
    realign_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_sync && !in_valid) |=> (state_q == SEQ_I));

endmodule

// File: rtl/cordic_vec_pipe.sv
module cordic_vec_pipe
    import iq_pkg::*;
#(
    parameter int IN_W   = 15,
    parameter int N_ITER = 16,
    parameter int GUARD  = 4,
    parameter int PH_W   = 16,
    parameter int AMP_W  = IN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   out_valid,
    output logic [AMP_W-1:0]       out_amp,
    output logic [PH_W-1:0]        out_phase
);

    localparam int XW     = IN_W + 3 + GUARD;
    localparam int AW     = PH_W + 2;
    localparam int PH_SH  = AW - PH_W;
    localparam int KC_W   = INV_GAIN_FRAC + 1;
    localparam int PW     = XW + KC_W;
    localparam int AMP_SH = INV_GAIN_FRAC + GUARD;

    localparam logic signed [AW-1:0] HALF_TURN = {1'b1, {(AW-1){1'b0}}};
    localparam logic signed [AW-1:0] PH_RND    = AW'(1 << (PH_SH - 1));
    localparam logic [PW-1:0]        AMP_RND   = PW'(1) << (AMP_SH - 1);
    localparam logic [PW-1:0]        AMP_MAX   = PW'((1 << AMP_W) - 1);
    localparam logic [PW-1:0]        KC        = PW'(CORDIC_INV_GAIN);

    logic signed [XW-1:0] x_q [0:N_ITER];
    logic signed [XW-1:0] y_q [0:N_ITER];
    logic signed [AW-1:0] z_q [0:N_ITER];
    logic                 v_q [0:N_ITER];
    logic                 zf_q[0:N_ITER];

    logic signed [XW-1:0] xi_ext;
    logic signed [XW-1:0] yq_ext;

    assign xi_ext = XW'(in_i) <<< GUARD;
    assign yq_ext = XW'(in_q) <<< GUARD;

    // Stage 0: fold the left half-plane onto the right one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q[0]  <= '0;
            y_q[0]  <= '0;
            z_q[0]  <= '0;
            v_q[0]  <= 1'b0;
            zf_q[0] <= 1'b0;
        end else begin
            v_q[0]  <= in_valid;
            zf_q[0] <= (in_i == '0) && (in_q == '0);
            if (in_i < 0) begin
                x_q[0] <= -xi_ext;
                y_q[0] <= -yq_ext;
                z_q[0] <= HALF_TURN;
            end else begin
                x_q[0] <= xi_ext;
                y_q[0] <= yq_ext;
                z_q[0] <= '0;
            end
        end
    end

    // Micro-rotation stages driving y towards zero
    for (genvar s = 0; s < N_ITER; s++) begin : g_iter
        localparam int RAW = atan_pi17(s);
        localparam int ASH = AW - 18;
        localparam logic signed [AW-1:0] ANG =
            AW'((ASH >= 0) ? (RAW <<< ASH) : (RAW >>> (-ASH)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                x_q[s+1]  <= '0;
                y_q[s+1]  <= '0;
                z_q[s+1]  <= '0;
                v_q[s+1]  <= 1'b0;
                zf_q[s+1] <= 1'b0;
            end else begin
                v_q[s+1]  <= v_q[s];
                zf_q[s+1] <= zf_q[s];
                if (!y_q[s][XW-1]) begin
                    x_q[s+1] <= x_q[s] + (y_q[s] >>> s);
                    y_q[s+1] <= y_q[s] - (x_q[s] >>> s);
                    z_q[s+1] <= z_q[s] + ANG;
                end else begin
                    x_q[s+1] <= x_q[s] - (y_q[s] >>> s);
                    y_q[s+1] <= y_q[s] + (x_q[s] >>> s);
                    z_q[s+1] <= z_q[s] - ANG;
                end
            end
        end

        // R5
        no_x_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[s+1] |-> !x_q[s+1][XW-1]);
    end

    // Gain correction, rounding and saturation
    logic [PW-1:0]        prod;
    logic [PW-1:0]        amp_full;
    logic [AMP_W-1:0]     amp_sat;
    logic signed [AW-1:0] z_rnd;

    always_comb begin
        prod     = PW'($unsigned(x_q[N_ITER])) * KC;
        amp_full = (prod + AMP_RND) >> AMP_SH;
        amp_sat  = (amp_full > AMP_MAX) ? AMP_W'(AMP_MAX) : AMP_W'(amp_full);
        z_rnd    = z_q[N_ITER] + PH_RND;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_amp   <= '0;
            out_phase <= '0;
        end else begin
            out_valid <= v_q[N_ITER];
            if (zf_q[N_ITER]) begin
                out_amp   <= '0;
                out_phase <= '0;
            end else begin
                out_amp   <= amp_sat;
                out_phase <= PH_W'(z_rnd >>> PH_SH);
            end
        end
    end

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_amp == '0) |-> (out_phase == '0));

endmodule

// File: rtl/beam_iq_phase_det.sv
module beam_iq_phase_det #(
    parameter int SAMPLE_W = 12,
    parameter int N_ITER   = 16,
    parameter int GUARD    = 4,
    parameter int PH_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] ch_a,
    input  logic [SAMPLE_W-1:0] ch_b,
    input  logic [SAMPLE_W-1:0] ch_c,
    input  logic [SAMPLE_W-1:0] ch_d,
    input  logic                rev_sync,
    output logic                out_valid,
    output logic [SAMPLE_W+2:0] out_amp,
    output logic [PH_W-1:0]     out_phase
);

    localparam int N_CH  = 4;
    localparam int IQ_W  = SAMPLE_W + $clog2(N_CH) + 1;
    localparam int AMP_W = IQ_W;

    logic [N_CH-1:0][SAMPLE_W-1:0] lanes;
    logic signed [IQ_W-1:0]        chan_sum;
    logic                          pair_valid;
    logic signed [IQ_W-1:0]        pair_i;
    logic signed [IQ_W-1:0]        pair_q;

    assign lanes = {ch_d, ch_c, ch_b, ch_a};

    iq_chan_sum #(
        .SAMPLE_W (SAMPLE_W),
        .N_CH     (N_CH),
        .IQ_W     (IQ_W)
    ) u_sum (
        .lanes (lanes),
        .sum   (chan_sum)
    );

    iq_pair_former #(
        .IQ_W (IQ_W)
    ) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .rev_sync   (rev_sync),
        .chan_sum   (chan_sum),
        .pair_valid (pair_valid),
        .pair_i     (pair_i),
        .pair_q     (pair_q)
    );

    cordic_vec_pipe #(
        .IN_W   (IQ_W),
        .N_ITER (N_ITER),
        .GUARD  (GUARD),
        .PH_W   (PH_W),
        .AMP_W  (AMP_W)
    ) u_cordic (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pair_valid),
        .in_i      (pair_i),
        .in_q      (pair_q),
        .out_valid (out_valid),
        .out_amp   (out_amp),
        .out_phase (out_phase)
    );

    // R8
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: tb/test_beam_iq_phase_det.sv
module test_beam_iq_phase_det;

    localparam int LAT_EDGES = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] ch_a = '0, ch_b = '0, ch_c = '0, ch_d = '0;
    logic        rev_sync = 1'b0;
    logic        out_valid;
    logic [14:0] out_amp;
    logic [15:0] out_phase;

    always #4 clk = ~clk;

    beam_iq_phase_det i_beam_iq_phase_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .ch_c      (ch_c),
        .ch_d      (ch_d),
        .rev_sync  (rev_sync),
        .out_valid (out_valid),
        .out_amp   (out_amp),
        .out_phase (out_phase)
    );

    typedef struct {
        int    ei;
        int    eq;
        int    due;
        string ctx;
    } exp_t;

    exp_t  exp_q[$];
    int    cyc = 0;
    int    ntests = 0;
    int    nfail = 0;
    int    bm_pos = 0;
    int    bm_hold = 0;
    bit    done = 1'b0;
    string ctx = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input bit ok, input string what,
                         input int act, input int expv);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    function automatic int wrap16(input int d);
        return ((d % 65536) + 65536 + 32768) % 65536 - 32768;
    endfunction

    // Drive one cycle of inputs and advance the reference model
    task automatic drive(input int a, input int b, input int c, input int d,
                         input bit v, input bit rev);
        int eff;
        int s;
        exp_t e;
        in_valid = v;
        rev_sync = rev;
        ch_a = 12'(a); ch_b = 12'(b); ch_c = 12'(c); ch_d = 12'(d);
        eff = rev ? 0 : bm_pos;
        if (v) begin
            s = a + b + c + d;
            if (eff >= 2) s = -s;
            if (eff == 0 || eff == 2) begin
                bm_hold = s;
            end else begin
                e.ei = bm_hold; e.eq = s; e.due = cyc + LAT_EDGES; e.ctx = ctx;
                exp_q.push_back(e);
            end
            bm_pos = (eff + 1) % 4;
        end else begin
            bm_pos = eff;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rev_sync = 1'b0;
    endtask

    task automatic send_vec(input int vi, input int vq);
        drive(vi / 2, vi - vi / 2, 0, 0, 1'b1, 1'b1);
        drive(0, 0, vq / 2, vq - vq / 2, 1'b1, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(rnd_s(), rnd_s(), rnd_s(), rnd_s(), 1'b0, 1'b0);
    endtask

    // Output checker against the bench model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R3", 1'b0, "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    int ae;
                    int aa;
                    int pa;
                    int pe;
                    e = exp_q.pop_front();
                    aa = int'(out_amp);
                    pa = int'($signed(out_phase));
                    check($sformatf("R8 (%s)", e.ctx), cyc == e.due, "latency", cyc, e.due);
                    if (e.ei == 0 && e.eq == 0) begin
                        check("R7", aa == 0, "zero amplitude", aa, 0);
                        check("R7", pa == 0, "zero phase", pa, 0);
                    end else begin
                        ae = int'($sqrt(real'(e.ei * e.ei + e.eq * e.eq)));
                        check($sformatf("R5 (%s)", e.ctx),
                              (aa - ae <= 2 + ae / 1024) && (ae - aa <= 2 + ae / 1024),
                              "amplitude", aa, ae);
                        if (ae >= 512) begin
                            pe = int'($atan2(real'(e.eq), real'(e.ei)) / 3.14159265358979 * 32768.0);
                            check($sformatf("R6 (%s)", e.ctx),
                                  wrap16(pa - pe) <= 16 && wrap16(pa - pe) >= -16,
                                  "phase", pa, wrap16(pe));
                        end
                    end
                end
            end else if (exp_q.size() != 0 && exp_q[0].due == cyc) begin
                check("R8", 1'b0, "missing result", cyc, exp_q[0].due);
                void'(exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            ntests++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", out_valid == 1'b0, "out_valid in reset", int'(out_valid), 0);
        check("R1", out_amp == '0, "out_amp in reset", int'(out_amp), 0);
        check("R1", out_phase == '0, "out_phase in reset", int'(out_phase), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all four positions, no strobe, first sample must be in-phase (R1)
        ctx = "R2";
        drive(300, 200, -100, 100, 1'b1, 1'b0);
        drive(100, 100, 100, 100, 1'b1, 1'b0);
        drive(-250, -250, 0, 0, 1'b1, 1'b0);
        drive(-100, -100, -100, -100, 1'b1, 1'b0);
        drive(1000, 0, 0, 0, 1'b1, 1'b0);
        drive(0, 0, 0, 0, 1'b1, 1'b0);
        drive(-600, -400, 0, 0, 1'b1, 1'b0);
        drive(0, 0, -200, -500, 1'b1, 1'b0);

        // R6: quadrant sweep and the +/- pi boundary
        ctx = "R6";
        send_vec(2000, 0);     send_vec(1414, 1414);
        send_vec(0, 2000);     send_vec(-1414, 1414);
        send_vec(-2000, 0);    send_vec(-1414, -1414);
        send_vec(0, -2000);    send_vec(1414, -1414);
        send_vec(2047, -1);    send_vec(-2047, 1);
        send_vec(-2047, -1);   send_vec(-700, 1900);

        // R7: zero and tiny vectors
        ctx = "R7";
        send_vec(0, 0);
        send_vec(1, 0);
        send_vec(0, -1);

        // R4: strobe with a sample, strobe without, strobe at a negated slot
        ctx = "R4";
        drive(900, 0, 0, 0, 1'b1, 1'b0);
        drive(700, 0, 0, 0, 1'b1, 1'b1);
        drive(0, 300, 0, 0, 1'b1, 1'b0);
        drive(800, 0, 0, 0, 1'b1, 1'b0);
        drive(0, 0, 0, 0, 1'b0, 1'b1);
        drive(-600, 0, 0, 0, 1'b1, 1'b0);
        drive(-500, 0, 0, 0, 1'b1, 1'b0);
        drive(400, 0, 0, 0, 1'b1, 1'b1);
        drive(0, 400, 0, 0, 1'b1, 1'b0);

        // R3: gaps inside and between pairs, invalid data on idle cycles
        ctx = "R3";
        drive(1200, 0, 0, 0, 1'b1, 1'b0);
        idle(3);
        drive(0, 900, 0, 0, 1'b1, 1'b0);
        idle(2);
        drive(-500, 0, 300, 0, 1'b1, 1'b0);
        idle(1);
        drive(0, 0, 0, 1100, 1'b1, 1'b0);
        idle(30);

        // R9: back-to-back stream
        ctx = "R9";
        for (int k = 0; k < 200; k++) drive(rnd_s(), rnd_s(), rnd_s(), rnd_s(), 1'b1, 1'b0);

        // Random mix of gaps and strobes
        ctx = "rand";
        for (int k = 0; k < 800; k++) begin
            drive(rnd_s(), rnd_s(), rnd_s(), rnd_s(),
                  $urandom_range(99) < 70, $urandom_range(49) == 0);
        end

        idle(40);
        check("R3", exp_q.size() == 0, "results outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule